// File: doc/BRIEF.md
# Flag Offset Programming Loader

This block holds the four threshold offsets that a pair of FIFOs compare against to raise their almost-empty and almost-full flags. Two offsets belong to each FIFO: the Y value sets the almost-empty distance and the X value sets the almost-full distance. The flag comparators and the FIFO storage are outside this block. They read the four offset outputs and `prog_done`.

The programming method is fixed once, at master reset. While `rst_n` is low, the block samples the three select inputs on every clock. The value it sees at the last low edge decides the method until the next master reset. There are three methods:

- A preset mode gives all four registers the same default value at once.
- A parallel mode takes four strobed words from the port A data lane.
- A serial mode shifts one 48-bit chain, one bit per enabled clock, through all four registers. The order is Y1, X1, Y2, X2, and each register is loaded most significant bit first.

Master reset is the only thing that clears the offsets or the method. A partial reset of the FIFOs does not reach this block, so programmed values survive it.

Top module: `flag_offset_loader`

## Requirements
- R1: `ofs_sel` is sampled at each rising `clk` edge while `rst_n` is low. The value from the last such edge selects the method as follows: 3'b000 serial, 3'b111 serial, 3'b001 parallel, 3'b010 preset 8, 3'b011 preset 16, 3'b100 preset 64, 3'b101 preset 256, 3'b110 preset 1024.
- R2: After master reset in serial or parallel mode, all four offsets read 0 and `prog_done` is 0. In a preset mode, all four offsets equal the preset and `prog_done` is 1 from the first cycle after release.
- R3: Changes on `ofs_sel` after `rst_n` has risen have no effect on the method.
- R4: In serial mode, each rising `clk` edge with `ser_en_n` low and `prog_done` low shifts `ser_bit` into the chain. After 48 such edges:
  - the first bit has reached `y1_ofs[11]`;
  - the registers fill in the order `y1_ofs`, `x1_ofs`, `y2_ofs`, `x2_ofs`, each MSB first;
  - the last bit sits in `x2_ofs[0]`.
- R5: A clock edge with `ser_en_n` high does not shift, and does not advance the bit count.
- R6: `prog_done` stays low after 47 accepted serial bits. It is high right after the edge that accepts the 48th bit.
- R7: Once `prog_done` is high, further serial shifts or parallel writes leave all four offsets unchanged, and `prog_done` stays high.
- R8: In parallel mode, each edge with `par_wr` high writes `par_val` into the next register in the order `y1_ofs`, `x1_ofs`, `y2_ofs`, `x2_ofs`. `prog_done` rises after the fourth write.
- R9: `ser_en_n` and `ser_bit` are ignored in parallel and preset modes. `par_wr` is ignored in serial and preset modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port A clock |
| rst_n | input | 1 | Master reset, active low, synchronous |
| ofs_sel | input | 3 | Method and preset select, sampled during master reset |
| ser_bit | input | 1 | Serial offset data |
| ser_en_n | input | 1 | Serial shift enable, active low |
| par_wr | input | 1 | Parallel offset write strobe |
| par_val | input | OFS_W | Parallel offset value from the port A data lane |
| y1_ofs | output | OFS_W | Almost-empty offset, FIFO 1 |
| x1_ofs | output | OFS_W | Almost-full offset, FIFO 1 |
| y2_ofs | output | OFS_W | Almost-empty offset, FIFO 2 |
| x2_ofs | output | OFS_W | Almost-full offset, FIFO 2 |
| prog_done | output | 1 | All four offsets programmed |

## Verification
The serial load is driven with several bit patterns: alternating nibbles, whole registers of ones next to registers of zeros, ascending hex digits, and a lone set bit at each end of the chain. A swapped register order, a reversed bit order or a misplaced shift boundary each give a different readback on these patterns. Every preset code is checked against its numeric value, and the 3'b111 alias is checked to select serial mode. Pauses with the enable high, extra bits after completion, and select changes after release each separate the correct behaviour from a design that counts, shifts or re-samples at the wrong time. In parallel mode, a fifth write and serial activity must both leave the four words as they were, and in serial mode parallel strobes must do the same.

// File: rtl/flag_offset_loader.sv
module flag_offset_loader #(
  parameter int OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       ofs_sel,
  input  logic             ser_bit,
  input  logic             ser_en_n,
  input  logic             par_wr,
  input  logic [OFS_W-1:0] par_val,
  output logic [OFS_W-1:0] y1_ofs,
  output logic [OFS_W-1:0] x1_ofs,
  output logic [OFS_W-1:0] y2_ofs,
  output logic [OFS_W-1:0] x2_ofs,
  output logic             prog_done
);

  localparam int NUM_OFS = 4;
  localparam int CHAIN_W = NUM_OFS * OFS_W;
  localparam int BC_W    = $clog2(CHAIN_W + 1);
  localparam int WC_W    = $clog2(NUM_OFS + 1);

  typedef enum logic [1:0] {M_SER, M_PAR, M_PRE} mode_t;

  mode_t              mode, sel_mode;
  logic [OFS_W-1:0]   sel_preset;
  logic [CHAIN_W-1:0] chain, chain_nx;
  logic [BC_W-1:0]    bit_cnt;
  logic [WC_W-1:0]    wr_cnt;
  logic               ser_step, par_step;

  always_comb begin
    sel_mode   = M_PRE;
    sel_preset = '0;
    case (ofs_sel)
      3'b001:  sel_mode   = M_PAR;
      3'b010:  sel_preset = OFS_W'(8);
      3'b011:  sel_preset = OFS_W'(16);
      3'b100:  sel_preset = OFS_W'(64);
      3'b101:  sel_preset = OFS_W'(256);
      3'b110:  sel_preset = OFS_W'(1024);
      default: sel_mode   = M_SER;
    endcase
  end

  assign prog_done = (mode == M_PRE) || (bit_cnt == BC_W'(CHAIN_W)) || (wr_cnt == WC_W'(NUM_OFS));
  assign ser_step  = (mode == M_SER) && !ser_en_n && !prog_done;
  assign par_step  = (mode == M_PAR) && par_wr && !prog_done;

  always_comb begin
    chain_nx = chain;
    if (ser_step) chain_nx = {chain[CHAIN_W-2:0], ser_bit};
    for (int i = 0; i < NUM_OFS; i++)
      if (par_step && wr_cnt == WC_W'(i))
        chain_nx[(NUM_OFS-i)*OFS_W-1 -: OFS_W] = par_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= sel_mode;
      chain   <= (sel_mode == M_PRE) ? {NUM_OFS{sel_preset}} : '0;
      bit_cnt <= '0;
      wr_cnt  <= '0;
    end else begin
      chain <= chain_nx;
      if (ser_step) bit_cnt <= bit_cnt + 1'b1;
      if (par_step) wr_cnt  <= wr_cnt + 1'b1;
    end
  end

  assign y1_ofs = chain[4*OFS_W-1 -: OFS_W];
  assign x1_ofs = chain[3*OFS_W-1 -: OFS_W];
  assign y2_ofs = chain[2*OFS_W-1 -: OFS_W];
  assign x2_ofs = chain[OFS_W-1 -: OFS_W];

  AST_METHOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode)); // R3

  AST_SER_LSB_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SER && !ser_en_n && !prog_done) |=> x2_ofs[0] == $past(ser_bit)); // R4

  AST_SER_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SER && ser_en_n) |=> $stable({y1_ofs, x1_ofs, y2_ofs, x2_ofs}) && $stable(bit_cnt)); // R5

  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> prog_done && $stable({y1_ofs, x1_ofs, y2_ofs, x2_ofs})); // R7

  AST_PAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PAR && par_wr && wr_cnt == '0) |=> y1_ofs == $past(par_val)); // R8

  AST_NO_STRAY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_SER && !(mode == M_PAR && par_wr)) |=> $stable({y1_ofs, x1_ofs, y2_ofs, x2_ofs})); // R9

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= BC_W'(CHAIN_W) && wr_cnt <= WC_W'(NUM_OFS)); // R6

endmodule

// File: tb/flag_offset_loader_tb.sv
module flag_offset_loader_tb_top;
  localparam int OFS_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] ofs_sel = 3'b000;
  logic ser_bit = 1'b0;
  logic ser_en_n = 1'b1;
  logic par_wr = 1'b0;
  logic [OFS_W-1:0] par_val = '0;
  logic [OFS_W-1:0] y1_ofs, x1_ofs, y2_ofs, x2_ofs;
  logic prog_done;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  flag_offset_loader #(.OFS_W(OFS_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ofs_sel(ofs_sel), .ser_bit(ser_bit),
    .ser_en_n(ser_en_n), .par_wr(par_wr), .par_val(par_val),
    .y1_ofs(y1_ofs), .x1_ofs(x1_ofs), .y2_ofs(y2_ofs), .x2_ofs(x2_ofs),
    .prog_done(prog_done));

  // sel in [50:48], serial pattern (first bit = MSB) in [47:0]
  localparam logic [50:0] VECS [0:9] = '{
    {3'b000, 48'hA5C3F081E7B2}, {3'b000, 48'hFFF000FFF000},
    {3'b000, 48'h123456789ABC}, {3'b111, 48'h800000000001},
    {3'b111, 48'h000FFF000FFF}, {3'b010, 48'h0},
    {3'b011, 48'h0}, {3'b100, 48'h0}, {3'b101, 48'h0}, {3'b110, 48'h0}};

  function automatic logic [OFS_W-1:0] preset_of(input logic [2:0] s);
    case (s)
      3'b010: return 12'd8;
      3'b011: return 12'd16;
      3'b100: return 12'd64;
      3'b101: return 12'd256;
      default: return 12'd1024;
    endcase
  endfunction

  function automatic logic [48:0] obs();
    return {prog_done, y1_ofs, x1_ofs, y2_ofs, x2_ofs};
  endfunction

  task automatic check(input string req, input logic [48:0] act, input logic [48:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] s);
    @(negedge clk);
    rst_n = 1'b0; ofs_sel = s; ser_en_n = 1'b1; par_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic shift_n(input logic [47:0] pat, input int first, input int n);
    for (int i = first; i < first + n; i++) begin
      ser_en_n = 1'b0; ser_bit = pat[47-i];
      @(negedge clk);
    end
    ser_en_n = 1'b1;
  endtask

  task automatic par_write(input logic [OFS_W-1:0] v);
    par_wr = 1'b1; par_val = v;
    @(negedge clk);
    par_wr = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int v = 0; v < 10; v++) begin
      logic [2:0] s;
      logic [47:0] p;
      s = VECS[v][50:48];
      p = VECS[v][47:0];
      do_reset(s);
      if (s == 3'b000 || s == 3'b111) begin
        check("R2 serial reset state", obs(), 49'h0);
        shift_n(p, 0, 48);
        check("R4 R1 serial load", obs(), {1'b1, p});
      end else begin
        check("R1 R2 preset value", obs(), {1'b1, {4{preset_of(s)}}});
      end
    end

    // R6 done timing and R7 post-done shifts
    do_reset(3'b000);
    shift_n(48'h5A5A5A5A5A5A, 0, 47);
    check("R6 not done at 47", {48'h0, prog_done}, 49'h0);
    shift_n(48'h5A5A5A5A5A5A, 47, 1);
    check("R6 done at 48", obs(), {1'b1, 48'h5A5A5A5A5A5A});
    shift_n(48'hFFFFFFFFFFFF, 0, 6);
    check("R7 extra bits ignored", obs(), {1'b1, 48'h5A5A5A5A5A5A});
    par_write(12'hABC);
    check("R7 R9 par write after serial done", obs(), {1'b1, 48'h5A5A5A5A5A5A});

    // R5 pause mid-load with toggling data
    do_reset(3'b000);
    shift_n(48'hC0FFEE123456, 0, 20);
    for (int k = 0; k < 6; k++) begin
      ser_bit = k[0];
      @(negedge clk);
    end
    check("R5 paused partial", obs(), {1'b0, 28'h0, 20'hC0FFE});
    shift_n(48'hC0FFEE123456, 20, 28);
    check("R5 resumed load", obs(), {1'b1, 48'hC0FFEE123456});

    // R3 select change after release
    do_reset(3'b000);
    ofs_sel = 3'b110;
    repeat (3) @(negedge clk);
    check("R3 sel change ignored state", obs(), 49'h0);
    shift_n(48'h0F0F0F0F0F0F, 0, 48);
    check("R3 still serial", obs(), {1'b1, 48'h0F0F0F0F0F0F});

    // R9 par_wr ignored in serial mode
    do_reset(3'b000);
    par_write(12'h777);
    par_write(12'h888);
    check("R9 par ignored in serial", obs(), 49'h0);

    // R8 parallel order, R9 serial ignored in parallel
    do_reset(3'b001);
    check("R2 parallel reset state", obs(), 49'h0);
    shift_n(48'hFFFFFFFFFFFF, 0, 10);
    check("R9 serial ignored in parallel", obs(), 49'h0);
    par_write(12'h111);
    check("R8 first word to y1", obs(), {1'b0, 12'h111, 36'h0});
    par_write(12'h222);
    par_write(12'h333);
    check("R8 not done at 3", {48'h0, prog_done}, 49'h0);
    par_write(12'h444);
    check("R8 four words", obs(), {1'b1, 48'h111222333444});
    par_write(12'h999);
    check("R7 fifth write ignored", obs(), {1'b1, 48'h111222333444});

    // R9 preset mode ignores both load paths
    do_reset(3'b100);
    shift_n(48'hFFFFFFFFFFFF, 0, 48);
    par_write(12'hFFF);
    check("R9 preset untouched", obs(), {1'b1, {4{12'd64}}});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule